// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating and Driver-Enable Timing

This block turns bytes into asynchronous serial frames on a single output line. A byte written through a one-deep holding register moves into a shift register when the line is free. It then goes out as one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line rests high. Each bit lasts 8 or 16 sample ticks. The ticks come from a baud-tick input that an outside divider provides.

Two optional handshakes wrap the serial stream. The first is an active-low clear-to-send input. When its gating is on, a waiting byte starts only while that input is low. The input is synchronised and is looked at only between characters, so a frame already on the line always runs to its end. Every change of the synchronised input sets a sticky change flag. The second handshake is a line-driver enable for a half-duplex transceiver. It turns on a programmable number of sample ticks before the start bit and turns off a programmable number of ticks after the last stop bit. Its polarity can be chosen. A byte written while the enable is still winding down reuses the open window. No new lead time is inserted.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, tx is 1, txe is 1, cts_chg is 0 and de is at its inactive level.
- R2: A frame is tx=0 for one bit, then data bits 0 to 7 in that order, then tx=1 for one bit. Each bit lasts 16 sample ticks when cfg_os8=0 and 8 when cfg_os8=1.
- R3: A write is taken only if txe is 1 at the clock edge where wr_valid is high. An accepted write clears txe. txe returns to 1 in the cycle the byte moves into the shifter. A write made while txe is 0 is dropped, and that includes a write in the very edge where the byte moves to the shifter.
- R4: If a byte is waiting when the last stop-bit tick ends, its start bit begins in the next cycle, so consecutive start bits are 10 bit times apart.
- R5: With cfg_cts_en=1 and cts_n high, a waiting byte is not started and txe stays 0. Once cts_n is low, the start bit follows through a two-flop synchroniser.
- R6: A frame in progress finishes with its full data and stop bit, however cts_n moves during it.
- R7: If cts_n goes low at least 3 clock cycles before the final stop tick, a waiting byte follows back to back.
- R8: Each change of cts_n sets cts_chg within 3 clock cycles. cts_chg stays at 1 until cts_chg_clr is pulsed while no new change is arriving.
- R9: With cfg_de_en=0, de equals the inverse of cfg_de_pol at all times. Active de is the value of cfg_de_pol.
- R10: With cfg_de_en=1, de becomes active exactly cfg_lead sample ticks before the start bit. A lead of 0 makes de active together with the start bit.
- R11: With cfg_de_en=1, de stays active for exactly cfg_lag sample ticks after the last stop tick and then goes inactive.
- R12: A byte written while de is in its lag period starts without de going inactive and without a new lead period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-cycle sample tick (8 or 16 per bit) |
| cfg_os8 | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cfg_de_en | input | 1 | Enable the driver-enable output |
| cfg_de_pol | input | 1 | Active level of de |
| cfg_lead | input | TIME_W | Driver-enable lead in sample ticks |
| cfg_lag | input | TIME_W | Driver-enable lag in sample ticks |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| cts_chg_clr | input | 1 | Clears the clear-to-send change flag |
| txe | output | 1 | Holding register empty |
| cts_chg | output | 1 | Sticky clear-to-send change flag |
| tx | output | 1 | Serial line, idles high |
| de | output | 1 | Line-driver enable |

## Verification
Two events can fall in the same clock edge: a new write, and the hand-off of the held byte into the shifter, which empties the register. A second case is a write that lands while de is winding down, so that the lag count and a new start compete in one cycle. The first collision is set up by holding a byte behind clear-to-send, releasing it, and timing a write to meet the exact edge where the synchroniser lets the start through. Random write gaps then add more such meetings. The bench judges each write from the txe it saw before the edge and compares the decoded byte stream against that list. For the lag case it checks that de never dropped between the two frames and that fewer ticks than the lag passed before the second start bit.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_LAG
  } tx_state_e;

  // Sample ticks per serial bit for the chosen oversampling rate.
  function automatic int unsigned samples_per_bit(input logic os8);
    return os8 ? 32'd8 : 32'd16;
  endfunction

  // Ticks from one start bit to the next in a back-to-back stream.
  function automatic int unsigned frame_ticks(input logic os8, input int unsigned data_w);
    return (data_w + 2) * samples_per_bit(os8);
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic wr_acc;

  // Writes land only into an empty register; a hand-off edge still counts as full.
  assign wr_acc = wr_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_acc) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

endmodule

// File: rtl/uart_cts_sync.sv
`timescale 1ns/1ps
module uart_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic clr,
  output logic cts_s,
  output logic chg
);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic              edge_ev;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= cts_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign cts_s   = chain[STAGES-1];
  assign edge_ev = cts_s ^ prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b1;
      chg  <= 1'b0;
    end else begin
      prev <= cts_s;
      if (edge_ev)  chg <= 1'b1;
      else if (clr) chg <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_engine.sv
`timescale 1ns/1ps
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              os8,
  input  logic              cts_ok,
  input  logic              de_en,
  input  logic [TIME_W-1:0] lead,
  input  logic [TIME_W-1:0] lag,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              phase_end,
  output logic              tx,
  output logic              de_act,
  output logic              eng_idle
);

  localparam int CNT_W = (TIME_W > 5) ? TIME_W : 5;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         st, st_nx;
  logic [CNT_W-1:0]  cnt, limit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sh;
  logic              can_go, use_lead, use_lag, last_bit;

  assign can_go   = hold_full && cts_ok;
  assign use_lead = de_en && (lead != '0);
  assign use_lag  = de_en && (lag != '0);
  assign last_bit = (idx == IDX_W'(DATA_W - 1));

  always_comb begin
    unique case (st)
      ST_LEAD: limit = CNT_W'(lead);
      ST_LAG:  limit = CNT_W'(lag);
      default: limit = CNT_W'(samples_per_bit(os8));
    endcase
  end

  assign phase_end = tick && (st != ST_IDLE) && (cnt == limit - 1'b1);

  always_comb begin
    st_nx = st;
    take  = 1'b0;
    unique case (st)
      ST_IDLE: if (can_go) begin
        take  = 1'b1;
        st_nx = use_lead ? ST_LEAD : ST_START;
      end
      ST_LEAD:  if (phase_end) st_nx = ST_START;
      ST_START: if (phase_end) st_nx = ST_DATA;
      ST_DATA:  if (phase_end && last_bit) st_nx = ST_STOP;
      ST_STOP: if (phase_end) begin
        if (can_go) begin
          take  = 1'b1;
          st_nx = ST_START;
        end else begin
          st_nx = use_lag ? ST_LAG : ST_IDLE;
        end
      end
      ST_LAG: begin
        if (can_go) begin
          take  = 1'b1;
          st_nx = ST_START;
        end else if (phase_end) begin
          st_nx = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st || phase_end) cnt <= '0;
      else if (tick && st != ST_IDLE) cnt <= cnt + 1'b1;
      if (st == ST_START) idx <= '0;
      else if (st == ST_DATA && phase_end) idx <= idx + 1'b1;
      if (take) sh <= hold_data;
      else if (st == ST_DATA && phase_end) sh <= sh >> 1;
    end
  end

  always_comb begin
    unique case (st)
      ST_START: tx = 1'b0;
      ST_DATA:  tx = sh[0];
      default:  tx = 1'b1;
    endcase
  end

  assign de_act   = de_en && (st != ST_IDLE);
  assign eng_idle = (st == ST_IDLE);

endmodule

// File: rtl/uart_tx_flow.sv
`timescale 1ns/1ps
module uart_tx_flow #(
  parameter int DATA_W      = 8,
  parameter int TIME_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tick,
  input  logic              cfg_os8,
  input  logic              cfg_cts_en,
  input  logic              cfg_de_en,
  input  logic              cfg_de_pol,
  input  logic [TIME_W-1:0] cfg_lead,
  input  logic [TIME_W-1:0] cfg_lag,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cts_n,
  input  logic              cts_chg_clr,
  output logic              txe,
  output logic              cts_chg,
  output logic              tx,
  output logic              de
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take, phase_end, de_act, eng_idle;
  logic              cts_s, cts_ok;

  uart_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_cts_sync #(.STAGES(SYNC_STAGES)) i_cts (
    .clk   (clk),
    .rst_n (rst_n),
    .cts_n (cts_n),
    .clr   (cts_chg_clr),
    .cts_s (cts_s),
    .chg   (cts_chg)
  );

  assign cts_ok = !cfg_cts_en || !cts_s;

  uart_tx_engine #(.DATA_W(DATA_W), .TIME_W(TIME_W)) i_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (smp_tick),
    .os8       (cfg_os8),
    .cts_ok    (cts_ok),
    .de_en     (cfg_de_en),
    .lead      (cfg_lead),
    .lag       (cfg_lag),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .phase_end (phase_end),
    .tx        (tx),
    .de_act    (de_act),
    .eng_idle  (eng_idle)
  );

  assign txe = !hold_full;
  assign de  = cfg_de_pol ? de_act : !de_act;

endmodule

// File: rtl/uart_tx_flow_chk.sv
`timescale 1ns/1ps
module uart_tx_flow_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_de_en,
  input logic              cfg_de_pol,
  input logic              de,
  input logic              tx,
  input logic              txe,
  input logic              take,
  input logic              cts_ok,
  input logic              hold_full,
  input logic [DATA_W-1:0] hold_data,
  input logic              cts_s,
  input logic              cts_chg,
  input logic              eng_idle
);

  a_r5_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> cts_ok);

  a_r3_handoff_empties: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> txe);

  a_r3_full_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take) |=> (hold_full && $stable(hold_data)));

  a_r9_de_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_de_en |-> (de == !cfg_de_pol));

  a_r10_de_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_de_en && $fell(tx)) |-> (de == cfg_de_pol));

  a_r8_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cts_s) || $fell(cts_s)) |=> cts_chg);

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> tx);

endmodule

bind uart_tx_flow uart_tx_flow_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_de_en  (cfg_de_en),
  .cfg_de_pol (cfg_de_pol),
  .de         (de),
  .tx         (tx),
  .txe        (txe),
  .take       (take),
  .cts_ok     (cts_ok),
  .hold_full  (hold_full),
  .hold_data  (hold_data),
  .cts_s      (cts_s),
  .cts_chg    (cts_chg),
  .eng_idle   (eng_idle)
);

// File: tb/test_uart_tx_flow.sv
`timescale 1ns/1ps
module test_uart_tx_flow;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_tick = 1'b0;
  logic       cfg_os8 = 1'b0, cfg_cts_en = 1'b0, cfg_de_en = 1'b0, cfg_de_pol = 1'b1;
  logic [4:0] cfg_lead = '0, cfg_lag = '0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cts_n = 1'b1, cts_chg_clr = 1'b0;
  logic       txe, cts_chg, tx, de;

  int n_chk = 0, n_err = 0;
  int tick_div = 1, tick_ph = 0, tick_no = 0;
  bit finished = 0;

  int exp_q[$], frm_q[$], ok_q[$], pre_q[$], lag_q[$], start_q[$];
  bit in_frame = 0, de_was = 0, de_on;
  int j = 0, idle_ticks = 0, de_bad = 0;
  logic [9:0] bits;

  uart_tx_flow i_uart_tx_flow (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .cfg_os8(cfg_os8),
    .cfg_cts_en(cfg_cts_en), .cfg_de_en(cfg_de_en), .cfg_de_pol(cfg_de_pol),
    .cfg_lead(cfg_lead), .cfg_lag(cfg_lag), .wr_valid(wr_valid), .wr_data(wr_data),
    .cts_n(cts_n), .cts_chg_clr(cts_chg_clr), .txe(txe), .cts_chg(cts_chg),
    .tx(tx), .de(de)
  );

  always #2 clk = ~clk;

  function automatic int spb_of(input logic os8);
    return os8 ? 8 : 16;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample tick generator, driven just after the rising edge.
  initial forever begin
    @(posedge clk); #1;
    tick_ph = (tick_ph + 1) % tick_div;
    smp_tick = (tick_ph == 0);
  end

  // Line monitor: decodes frames and measures driver-enable windows in ticks.
  always @(negedge clk) begin
    if (!rst_n) begin
      in_frame = 0; j = 0; idle_ticks = 0; de_was = 0;
    end else begin
      de_on = (de === cfg_de_pol);
      if (!cfg_de_en && de_on) de_bad++;
      if (!in_frame) begin
        if (tx === 1'b0) begin
          in_frame = 1; j = 0;
          pre_q.push_back(idle_ticks);
          idle_ticks = 0; de_was = de_on;
        end else if (de_on) begin
          if (smp_tick) idle_ticks++;
          de_was = 1;
        end else begin
          if (de_was) lag_q.push_back(idle_ticks);
          idle_ticks = 0; de_was = 0;
        end
      end
      if (in_frame && smp_tick) begin
        if (j == 0) start_q.push_back(tick_no);
        if (j % spb_of(cfg_os8) == spb_of(cfg_os8) / 2) bits[j / spb_of(cfg_os8)] = tx;
        j++;
        if (j == 10 * spb_of(cfg_os8)) begin
          in_frame = 0;
          frm_q.push_back(int'(bits[8:1]));
          ok_q.push_back(int'(!bits[0] && bits[9]));
          de_was = de_on;
        end
      end
      if (smp_tick) tick_no++;
    end
  end

  task automatic put(input logic [7:0] b, output bit acc);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    acc = txe;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    if (acc) exp_q.push_back(int'(b));
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 700) begin
      @(negedge clk);
      if (txe && tx && !in_frame && (de !== cfg_de_pol)) q++;
      else q = 0;
    end
  endtask

  task automatic compare(input string req);
    chk({req, " frame count"}, frm_q.size(), exp_q.size());
    for (int i = 0; i < frm_q.size() && i < exp_q.size(); i++) begin
      chk({req, " data"}, frm_q[i], exp_q[i]);
      chk({req, " start/stop levels"}, ok_q[i], 1);
    end
    exp_q.delete(); frm_q.delete(); ok_q.delete();
    pre_q.delete(); lag_q.delete(); start_q.delete();
  endtask

  task automatic set_cfg(input logic os8, input int div, input logic de_en, input logic pol,
                         input int lead, input int lag, input logic cts_en);
    @(posedge clk); #1;
    cfg_os8 = os8; tick_div = div; cfg_de_en = de_en; cfg_de_pol = pol;
    cfg_lead = 5'(lead); cfg_lag = 5'(lag); cfg_cts_en = cts_en;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk("watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit acc;
    void'($urandom(32'h5EED_0A17));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx after reset", tx, 1);
    chk("R1 txe after reset", txe, 1);
    chk("R1 cts_chg after reset", cts_chg, 0);
    chk("R1 de after reset", de, 0);

    // Back to back, a dropped write, 16x oversampling, enable off.
    set_cfg(1'b0, 1, 1'b0, 1'b1, 0, 0, 1'b0);
    put(8'hA5, acc);
    while (!txe) @(negedge clk);
    put(8'h3C, acc);
    put(8'hFF, acc);
    chk("R3 write while full dropped", int'(acc), 0);
    wait_quiet();
    chk("R4 start spacing", (start_q.size() == 2) ? start_q[1] - start_q[0] : -1, 160);
    compare("R2 directed");

    // Random stream: writes at random gaps, acceptance judged from txe.
    for (int k = 0; k < 40; k++) begin
      repeat ($urandom_range(0, 200)) @(posedge clk);
      put(8'($urandom), acc);
    end
    wait_quiet();
    compare("R3 random stream");
    chk("R9 de parked while disabled", de_bad, 0);

    // Driver-enable timing at 8x, sparse ticks, across several settings.
    for (int c = 0; c < 3; c++) begin
      int ld, lg;
      ld = (c == 0) ? 5 : (c == 1) ? 0 : 31;
      lg = (c == 0) ? 7 : (c == 1) ? 0 : 31;
      set_cfg(1'b1, 3, 1'b1, (c != 1), ld, lg, 1'b0);
      @(negedge clk);
      chk("R9 de inactive level when idle", de, (c != 1) ? 0 : 1);
      put(8'($urandom), acc);
      wait_quiet();
      chk("R10 lead ticks", (pre_q.size() > 0) ? pre_q[0] : -1, ld);
      chk("R11 lag ticks", (lag_q.size() > 0) ? lag_q[0] : -1, lg);
      compare("R2 8x frame");
    end

    // Write landing inside the lag window.
    set_cfg(1'b0, 1, 1'b1, 1'b1, 20, 12, 1'b0);
    put(8'h81, acc);
    while (frm_q.size() == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    put(8'h7E, acc);
    wait_quiet();
    chk("R10 lead before first byte", (pre_q.size() > 0) ? pre_q[0] : -1, 20);
    chk("R12 no new lead after lag write", (pre_q.size() > 1) ? int'(pre_q[1] < 12) : 0, 1);
    chk("R12 de stayed active between frames", lag_q.size(), 1);
    compare("R12 frames");

    // Clear-to-send hold, release colliding with a write.
    set_cfg(1'b0, 1, 1'b0, 1'b1, 0, 0, 1'b1);
    @(posedge clk); #1 cts_chg_clr = 1'b1;
    @(posedge clk); #1 cts_chg_clr = 1'b0;
    put(8'h5A, acc);
    repeat (300) @(negedge clk);
    chk("R5 held byte not started", frm_q.size() + int'(in_frame), 0);
    chk("R5 txe stays low while held", txe, 0);
    chk("R8 no change flagged yet", cts_chg, 0);
    @(posedge clk); #1 cts_n = 1'b0;
    @(posedge clk);
    put(8'hC3, acc);
    chk("R3 write at hand-off edge dropped", int'(acc), 0);
    chk("R8 change flagged within 3 cycles", cts_chg, 1);
    wait_quiet();
    compare("R5 released byte");
    @(posedge clk); #1 cts_chg_clr = 1'b1;
    @(posedge clk); #1 cts_chg_clr = 1'b0;
    @(negedge clk);
    chk("R8 flag cleared", cts_chg, 0);

    // Clear-to-send moving during frames.
    put(8'h11, acc);
    while (!txe) @(negedge clk);
    put(8'h22, acc);
    repeat (40) @(posedge clk);
    #1 cts_n = 1'b1;
    repeat (40) @(posedge clk);
    #1 cts_n = 1'b0;
    while (!txe) @(negedge clk);
    put(8'h33, acc);
    repeat (30) @(posedge clk);
    #1 cts_n = 1'b1;
    repeat (500) @(negedge clk);
    chk("R7 back to back after early release", (start_q.size() > 1) ? start_q[1] - start_q[0] : -1, 160);
    chk("R6 frames finished despite cts", frm_q.size(), 2);
    chk("R6 second frame data", (frm_q.size() > 1) ? frm_q[1] : -1, 8'h22);
    @(posedge clk); #1 cts_n = 1'b0;
    wait_quiet();
    compare("R6 cts stream");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule